// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand specifier into either an effective address or an operand value for a 32-bit load/store processor. Each request carries a mode code, two register indices, a signed constant field, the program counter and an operand-size bit. Register contents come back combinationally through two read ports of an external register file. The two auto-modifying modes return an updated register value through a single write port.

A memory-indirect request needs one pointer word from memory, so it takes more cycles than the other modes. For that mode the block drives a memory read and waits for the read-valid handshake before it reports a result. While it waits, `busy` is high and new requests are dropped. Every other mode produces a registered result one cycle after the request is accepted.

A result is tagged as an address, an immediate value or a register number. Back-to-back requests that touch a register which is still being written back see the new value through internal forwarding.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 0 (immediate) gives `out_kind`=1 and `out_value` equal to the sign-extended constant field. It causes no memory read and no register write. `out_valid` is high in the cycle after the accepting clock edge.
- R2: Mode code 1 (register) gives `out_kind`=2 and `out_value` equal to index Ri zero-extended. Mode code 2 (absolute) gives `out_kind`=0 and `out_value` equal to the sign-extended constant field.
- R3: Mode code 3 (register indirect) gives `out_kind`=0 and `out_value` equal to the content of Ri.
- R4: Mode code 5 (indexed) gives the content of Ri plus the sign-extended constant, wrapping modulo 2^32.
- R5: Mode code 6 gives the content of Ri plus the content of Rj. Mode code 7 adds the sign-extended constant to that sum as well. Both wrap modulo 2^32.
- R6: Mode code 8 (PC-relative) gives `req_pc` plus the sign-extended constant.
- R7: Mode code 4 (memory indirect) behaves as follows. From the cycle after acceptance, `mem_rd_en` and `busy` stay high and `mem_rd_addr` holds the sign-extended constant, until a cycle in which `mem_rd_valid` is high. In the next cycle `out_valid` is high with `out_value` equal to the `mem_rd_data` that was sampled. While `busy` is high, requests are ignored.
- R8: Mode code 9 (post-increment) gives the old content of Ri as the address and writes Ri + step back to Ri. The step is 4 when `req_word`=1 and 1 when it is 0.
- R9: Mode code 10 (pre-decrement) computes Ri - step. That value is both the address and the value written back to Ri.
- R10: A request accepted in the cycle in which a write-back to its Ri is pending uses the written-back value.
- R11: Mode codes 11 to 15 produce no `out_valid`, no register write and no memory read.
- R12: While `rst` is high and right after it, `out_valid`, `rf_we`, `mem_rd_en` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 4 | Addressing mode code |
| req_ri | input | 3 | Primary register index |
| req_rj | input | 3 | Secondary register index |
| req_disp | input | 16 | Signed constant / offset / address field |
| req_pc | input | 32 | Current program counter |
| req_word | input | 1 | 1: word operand (step 4), 0: byte operand (step 1) |
| busy | output | 1 | Waiting on a memory-indirect read |
| rf_ra_idx | output | 3 | Register read port A index |
| rf_ra_data | input | 32 | Register read port A data |
| rf_rb_idx | output | 3 | Register read port B index |
| rf_rb_data | input | 32 | Register read port B data |
| rf_we | output | 1 | Register write-back enable |
| rf_widx | output | 3 | Register write-back index |
| rf_wdata | output | 32 | Register write-back data |
| mem_rd_en | output | 1 | Memory pointer read request |
| mem_rd_addr | output | 32 | Memory pointer read address |
| mem_rd_data | input | 32 | Memory read data |
| mem_rd_valid | input | 1 | Memory read data valid |
| out_valid | output | 1 | Result strobe |
| out_kind | output | 2 | 0 address, 1 immediate, 2 register number |
| out_value | output | 32 | Effective address or operand |

## Verification
The hardest case to reach is a register read that overlaps a pending write-back. It only happens when two auto-modifying requests on the same register come in consecutive cycles. The bench holds `req_valid` high across two edges for that case, then reads the register back through a register-indirect request to confirm the final value. The memory-indirect wait is stretched over several cycles, and a competing request is driven during the wait to show that it is dropped.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;
  localparam int KIND_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM   = 4'd0,
    AM_REG   = 4'd1,
    AM_ABS   = 4'd2,
    AM_RIND  = 4'd3,
    AM_MIND  = 4'd4,
    AM_IDX   = 4'd5,
    AM_BIDX  = 4'd6,
    AM_BIDXO = 4'd7,
    AM_REL   = 4'd8,
    AM_PINC  = 4'd9,
    AM_PDEC  = 4'd10
  } am_mode_e;

  localparam logic [MODE_W-1:0] AM_LAST = 4'd10;

  typedef enum logic [KIND_W-1:0] {
    K_ADDR = 2'd0,
    K_IMM  = 2'd1,
    K_REG  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/eag_fwd.sv
module eag_fwd #(
  parameter int DW  = 32,
  parameter int RIW = 3,
  parameter int NP  = 2
) (
  input  logic [NP-1:0][RIW-1:0] rd_idx,
  input  logic [NP-1:0][DW-1:0]  rd_data,
  input  logic                   wb_en,
  input  logic [RIW-1:0]         wb_idx,
  input  logic [DW-1:0]          wb_data,
  output logic [NP-1:0][DW-1:0]  rd_val
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    always_comb begin
      if (wb_en && (wb_idx == rd_idx[p])) rd_val[p] = wb_data;
      else                                rd_val[p] = rd_data[p];
    end
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 3,
  parameter int XW  = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [RIW-1:0]    ri,
  input  logic [DW-1:0]     ra,
  input  logic [DW-1:0]     rb,
  input  logic [XW-1:0]     disp,
  input  logic [DW-1:0]     pc,
  input  logic              word,
  output logic              legal,
  output logic              needs_mem,
  output logic [KIND_W-1:0] kind,
  output logic [DW-1:0]     value,
  output logic              wb_en,
  output logic              wb_inc,
  output logic [DW-1:0]     wb_data,
  output logic [DW-1:0]     step,
  output logic [DW-1:0]     xsext
);
  localparam int WORD_BYTES = DW / 8;

  logic [DW-1:0] dec_val;

  assign xsext   = {{(DW-XW){disp[XW-1]}}, disp};
  assign step    = word ? DW'(WORD_BYTES) : DW'(1);
  assign dec_val = ra - step;
  assign legal   = (mode <= AM_LAST);

  always_comb begin
    kind      = K_ADDR;
    value     = '0;
    wb_en     = 1'b0;
    wb_inc    = 1'b0;
    wb_data   = '0;
    needs_mem = 1'b0;
    case (mode)
      AM_IMM:   begin kind = K_IMM; value = xsext; end
      AM_REG:   begin kind = K_REG; value = {{(DW-RIW){1'b0}}, ri}; end
      AM_ABS:   value = xsext;
      AM_RIND:  value = ra;
      AM_MIND:  needs_mem = 1'b1;
      AM_IDX:   value = ra + xsext;
      AM_BIDX:  value = ra + rb;
      AM_BIDXO: value = ra + rb + xsext;
      AM_REL:   value = pc + xsext;
      AM_PINC:  begin value = ra; wb_en = 1'b1; wb_inc = 1'b1; wb_data = ra + step; end
      AM_PDEC:  begin value = dec_val; wb_en = 1'b1; wb_data = dec_val; end
      default:  value = '0;
    endcase
  end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [RIW-1:0]    req_ri,
  input  logic              legal,
  input  logic              needs_mem,
  input  logic [KIND_W-1:0] kind,
  input  logic [DW-1:0]     value,
  input  logic              wb_en,
  input  logic              wb_inc,
  input  logic [DW-1:0]     wb_data,
  input  logic [DW-1:0]     step,
  input  logic [DW-1:0]     xsext,
  input  logic [DW-1:0]     mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [DW-1:0]     mem_rd_addr,
  output logic              rf_we,
  output logic [RIW-1:0]    rf_widx,
  output logic [DW-1:0]     rf_wdata,
  output logic              out_valid,
  output logic [KIND_W-1:0] out_kind,
  output logic [DW-1:0]     out_value
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e           st;
  logic          inc_q;
  logic [DW-1:0] step_q;

  assign busy      = (st == S_WAIT);
  assign mem_rd_en = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      out_valid   <= 1'b0;
      out_kind    <= K_ADDR;
      out_value   <= '0;
      rf_we       <= 1'b0;
      rf_widx     <= '0;
      rf_wdata    <= '0;
      mem_rd_addr <= '0;
      inc_q       <= 1'b0;
      step_q      <= '0;
    end else begin
      out_valid <= 1'b0;
      rf_we     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && legal) begin
            if (needs_mem) begin
              st          <= S_WAIT;
              mem_rd_addr <= xsext;
            end else begin
              out_valid <= 1'b1;
              out_kind  <= kind;
              out_value <= value;
              rf_we     <= wb_en;
              rf_widx   <= req_ri;
              rf_wdata  <= wb_data;
              inc_q     <= wb_inc;
              step_q    <= step;
            end
          end
        end
        S_WAIT: begin
          if (mem_rd_valid) begin
            st        <= S_IDLE;
            out_valid <= 1'b1;
            out_kind  <= K_ADDR;
            out_value <= mem_rd_data;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WB_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> out_valid && (out_kind == K_ADDR)); // R8
  AST_PINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (rf_we && inc_q) |-> ((rf_wdata - out_value) == step_q)); // R8
  AST_PDEC_SAME: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !inc_q) |-> (rf_wdata == out_value)); // R9
  AST_MRD_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> $stable(mem_rd_addr)); // R7
  AST_WAIT_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rd_valid) |=> !out_valid); // R7
  AST_WAIT_NO_WB: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rf_we); // R7
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import eag_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 3,
  parameter int XW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [RIW-1:0]    req_ri,
  input  logic [RIW-1:0]    req_rj,
  input  logic [XW-1:0]     req_disp,
  input  logic [DW-1:0]     req_pc,
  input  logic              req_word,
  output logic              busy,
  output logic [RIW-1:0]    rf_ra_idx,
  input  logic [DW-1:0]     rf_ra_data,
  output logic [RIW-1:0]    rf_rb_idx,
  input  logic [DW-1:0]     rf_rb_data,
  output logic              rf_we,
  output logic [RIW-1:0]    rf_widx,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_rd_en,
  output logic [DW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              out_valid,
  output logic [KIND_W-1:0] out_kind,
  output logic [DW-1:0]     out_value
);
  logic [1:0][RIW-1:0] rd_idx;
  logic [1:0][DW-1:0]  rd_raw, rd_fwd;
  logic                legal, needs_mem, wb_en, wb_inc;
  logic [KIND_W-1:0]   kind;
  logic [DW-1:0]       value, wb_data, step, xsext;

  assign rf_ra_idx = req_ri;
  assign rf_rb_idx = req_rj;
  assign rd_idx    = {req_rj, req_ri};
  assign rd_raw    = {rf_rb_data, rf_ra_data};

  eag_fwd #(.DW(DW), .RIW(RIW), .NP(2)) u_fwd (
    .rd_idx(rd_idx), .rd_data(rd_raw), .wb_en(rf_we),
    .wb_idx(rf_widx), .wb_data(rf_wdata), .rd_val(rd_fwd)
  );

  eag_calc #(.DW(DW), .RIW(RIW), .XW(XW)) u_calc (
    .mode(req_mode), .ri(req_ri), .ra(rd_fwd[0]), .rb(rd_fwd[1]),
    .disp(req_disp), .pc(req_pc), .word(req_word),
    .legal(legal), .needs_mem(needs_mem), .kind(kind), .value(value),
    .wb_en(wb_en), .wb_inc(wb_inc), .wb_data(wb_data), .step(step),
    .xsext(xsext)
  );

  eag_seq #(.DW(DW), .RIW(RIW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ri(req_ri),
    .legal(legal), .needs_mem(needs_mem), .kind(kind), .value(value),
    .wb_en(wb_en), .wb_inc(wb_inc), .wb_data(wb_data), .step(step),
    .xsext(xsext), .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .out_valid(out_valid), .out_kind(out_kind), .out_value(out_value)
  );

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && (req_mode > AM_LAST)) |=> (!out_valid && !rf_we && !mem_rd_en)); // R11
  AST_IMM_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && (req_mode == AM_IMM)) |=> (out_valid && !rf_we && !mem_rd_en)); // R1
  AST_MIND_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && (req_mode == AM_MIND)) |=> (mem_rd_en && busy && !out_valid)); // R7
endmodule

// File: tb/ea_gen_unit_bench.sv
module ea_gen_unit_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic [3:0]  req_mode = 0;
  logic [2:0]  req_ri = 0, req_rj = 0;
  logic [15:0] req_disp = 0;
  logic [31:0] req_pc = 0;
  logic        req_word = 0;
  logic        busy, rf_we, mem_rd_en, out_valid;
  logic [2:0]  rf_ra_idx, rf_rb_idx, rf_widx;
  logic [31:0] rf_ra_data, rf_rb_data, rf_wdata, mem_rd_addr, out_value;
  logic [31:0] mem_rd_data = 0;
  logic        mem_rd_valid = 0;
  logic [1:0]  out_kind;
  logic [31:0] rf [8];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) rf[i] <= 32'h100 * i;
      rf[3] <= 32'hFFFF_FFFE;
    end else if (rf_we) rf[rf_widx] <= rf_wdata;
  end
  assign rf_ra_data = rf[rf_ra_idx];
  assign rf_rb_data = rf[rf_rb_idx];

  ea_gen_unit u_ea_gen_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_ri(req_ri), .req_rj(req_rj), .req_disp(req_disp), .req_pc(req_pc),
    .req_word(req_word), .busy(busy), .rf_ra_idx(rf_ra_idx),
    .rf_ra_data(rf_ra_data), .rf_rb_idx(rf_rb_idx), .rf_rb_data(rf_rb_data),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_valid(mem_rd_valid), .out_valid(out_valid), .out_kind(out_kind),
    .out_value(out_value)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_req(input logic [3:0] m, input logic [2:0] ri, input logic [2:0] rj,
                         input logic [15:0] x, input logic [31:0] pc, input logic w);
    req_mode = m; req_ri = ri; req_rj = rj; req_disp = x; req_pc = pc; req_word = w;
    req_valid = 1;
  endtask

  // one request, accepted at the next edge; returns at the negedge where the result shows
  task automatic send(input logic [3:0] m, input logic [2:0] ri, input logic [2:0] rj,
                      input logic [15:0] x, input logic [31:0] pc, input logic w);
    @(negedge clk);
    set_req(m, ri, rj, x, pc, w);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R12 out_valid", {31'd0, out_valid}, 0);
    chk("R12 rf_we", {31'd0, rf_we}, 0);
    chk("R12 mem_rd_en", {31'd0, mem_rd_en}, 0);
    chk("R12 busy", {31'd0, busy}, 0);
  endtask

  task automatic t_imm;
    send(4'd0, 3'd2, 3'd0, 16'hFF80, 32'h0, 1);
    chk("R1 valid", {31'd0, out_valid}, 1);
    chk("R1 kind", {30'd0, out_kind}, 1);
    chk("R1 value", out_value, 32'hFFFF_FF80);
    chk("R1 no write", {31'd0, rf_we}, 0);
    chk("R1 no read", {31'd0, mem_rd_en}, 0);
  endtask

  task automatic t_reg_abs;
    send(4'd1, 3'd6, 3'd0, 16'h0, 32'h0, 1);
    chk("R2 reg kind", {30'd0, out_kind}, 2);
    chk("R2 reg value", out_value, 32'd6);
    send(4'd2, 3'd0, 3'd0, 16'h8010, 32'h0, 1);
    chk("R2 abs kind", {30'd0, out_kind}, 0);
    chk("R2 abs value", out_value, 32'hFFFF_8010);
  endtask

  task automatic t_arith;
    send(4'd3, 3'd7, 3'd0, 16'h0, 32'h0, 1);
    chk("R3 rind", out_value, 32'h700);
    send(4'd5, 3'd2, 3'd0, 16'hFFFC, 32'h0, 1);
    chk("R4 idx neg", out_value, 32'h1FC);
    send(4'd5, 3'd3, 3'd0, 16'h0004, 32'h0, 1);
    chk("R4 idx wrap", out_value, 32'h2);
    send(4'd6, 3'd2, 3'd3, 16'h0, 32'h0, 1);
    chk("R5 bidx", out_value, 32'h1FE);
    send(4'd7, 3'd2, 3'd3, 16'h0010, 32'h0, 1);
    chk("R5 bidxo", out_value, 32'h20E);
    send(4'd8, 3'd0, 3'd0, 16'hFFF0, 32'h2000, 1);
    chk("R6 rel", out_value, 32'h1FF0);
  endtask

  task automatic t_mind;
    send(4'd4, 3'd1, 3'd0, 16'h0040, 32'h0, 1);
    chk("R7 no result yet", {31'd0, out_valid}, 0);
    chk("R7 rd_en", {31'd0, mem_rd_en}, 1);
    chk("R7 busy", {31'd0, busy}, 1);
    chk("R7 rd_addr", mem_rd_addr, 32'h40);
    set_req(4'd0, 3'd0, 3'd0, 16'h0055, 32'h0, 1); // must be dropped
    @(negedge clk);
    req_valid = 0;
    chk("R7 ignored while busy", {31'd0, out_valid}, 0);
    chk("R7 still reading", {31'd0, mem_rd_en}, 1);
    mem_rd_valid = 1; mem_rd_data = 32'hCAFE_0010;
    @(negedge clk);
    mem_rd_valid = 0; mem_rd_data = 0;
    chk("R7 valid", {31'd0, out_valid}, 1);
    chk("R7 value", out_value, 32'hCAFE_0010);
    chk("R7 kind", {30'd0, out_kind}, 0);
    chk("R7 idle", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R7 dropped req no result", {31'd0, out_valid}, 0);
  endtask

  task automatic t_auto;
    send(4'd9, 3'd4, 3'd0, 16'h0, 32'h0, 0);
    chk("R8 addr", out_value, 32'h400);
    chk("R8 we", {31'd0, rf_we}, 1);
    chk("R8 wdata byte", rf_wdata, 32'h401);
    send(4'd3, 3'd4, 3'd0, 16'h0, 32'h0, 1);
    chk("R8 reg updated", out_value, 32'h401);
    send(4'd10, 3'd5, 3'd0, 16'h0, 32'h0, 1);
    chk("R9 addr", out_value, 32'h4FC);
    chk("R9 wdata", rf_wdata, 32'h4FC);
    chk("R9 widx", {29'd0, rf_widx}, 5);
  endtask

  task automatic t_fwd;
    @(negedge clk);
    set_req(4'd9, 3'd1, 3'd0, 16'h0, 32'h0, 1);
    @(negedge clk);
    chk("R10 first addr", out_value, 32'h100);
    chk("R10 first wdata", rf_wdata, 32'h104);
    @(negedge clk);
    req_valid = 0;
    chk("R10 second addr", out_value, 32'h104);
    chk("R10 second wdata", rf_wdata, 32'h108);
    send(4'd3, 3'd1, 3'd0, 16'h0, 32'h0, 1);
    chk("R10 final reg", out_value, 32'h108);
  endtask

  task automatic t_reserved;
    for (int m = 11; m < 16; m++) begin
      send(4'(m), 3'd2, 3'd0, 16'h1, 32'h0, 1);
      chk("R11 no valid", {31'd0, out_valid}, 0);
      chk("R11 no write", {31'd0, rf_we}, 0);
      chk("R11 no read", {31'd0, mem_rd_en}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_imm();
    t_reg_abs();
    t_arith();
    t_mind();
    t_auto();
    t_fwd();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule